// File: doc/BRIEF.md
# One's Complement End-Around-Carry Adder

This block adds two signed words held in one's complement form. A binary adder forms the raw sum. Its carry out of the top bit is then added back into the bottom bit, which is the end-around carry. The carry is folded back through a wider intermediate sum, so the netlist has no combinational loop, and the result settles within one pass of carry propagation.

An optional single-bit carry input is not fed into the first adder. A second end-around adder of full width adds it instead. That adder takes the first sum as one operand, and as the other a word that is zero in every bit except the lowest, which holds the carry input.

The result may be registered, with one cycle of latency, or left combinational. Both encodings of zero are legal results. A parameter can rewrite the all-ones word (negative zero) to all zeros. An overflow flag marks results whose true signed value lies outside the representable range.

Top module: `ones_comp_adder`

## Requirements
- R1: While rstN is low, with the output register enabled (REG_OUT=1), sumOut and overflow are zero.
- R2: When the signed total of opA, opB and the effective carry input lies within ±(2^(WIDTH-1)-1), sumOut encodes that total in one's complement: the top bit is the sign, and a negative value -k is the bitwise inverse of k.
- R3: When the binary sum of the two operands carries out of bit WIDTH-1, that carry is added into bit 0. For example, 8'hFE + 8'hFE gives 8'hFD, which is -2.
- R4: With THREE_INPUT=1, carryIn adds one to the signed total. The all-ones word plus carryIn=1 gives 8'h01.
- R5: overflow is 1 exactly when the signed total lies outside ±(2^(WIDTH-1)-1). sumOut then holds the total reduced modulo 2^WIDTH-1. Two wraps that cancel (the first sum overflows and the carry input brings it back) leave overflow at 0.
- R6: A zero total gives all zeros only when opA and opB are both all zeros and the effective carry input is 0. Every other zero total gives all ones.
- R7: With FOLD_NEG_ZERO=1, an all-ones result is replaced by all zeros. overflow is unaffected.
- R8: With THREE_INPUT=0, carryIn has no effect on sumOut or overflow.
- R9: With REG_OUT=1, sumOut and overflow show the result of the inputs present at the previous rising clock edge. With REG_OUT=0 they follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | WIDTH | First operand, one's complement |
| opB | input | WIDTH | Second operand, one's complement |
| carryIn | input | 1 | One-bit addend, used only when THREE_INPUT=1 |
| sumOut | output | WIDTH | One's complement sum |
| overflow | output | 1 | High when the signed total is out of range |

## Verification
The bench goes after operand pairs whose binary sum carries out of the top bit. A design that drops the end-around carry would return a result one too small there. It drives the largest positive value with negative zero and carryIn=1, which must overflow. It also drives the case where the first adder overflows and the carry input cancels the wrap. Combining the two stage flags with OR instead of XOR would raise a false overflow on that case. Sums equal to zero are checked for the exact encoding, so a design that normalises zero unasked, or fails to when FOLD_NEG_ZERO is set, is caught. Two small-width instances are run exhaustively: one checks the fold and combinational timing, the other checks that carryIn is ignored in the two-input variant.

// File: rtl/oca_pkg.sv
package oca_pkg;
  localparam int OCA_STAGES = 2;

  typedef struct packed {
    logic useCarryIn;
    logic foldZero;
    logic bypass;
    logic capture;
  } oca_ctrl_t;
endpackage

// File: rtl/eac_adder.sv
module eac_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] addA,
  input  logic [W-1:0] addB,
  output logic [W-1:0] sum,
  output logic         ovf
);
  localparam int WIDE = W + 1;

  logic [WIDE-1:0] wideSum;
  logic [W-1:0]    wrapIn;

  assign wideSum = {1'b0, addA} + {1'b0, addB};
  // the low part is at most 2^W-2 when a carry exists, so adding it back never carries again
  assign wrapIn  = {{(W-1){1'b0}}, wideSum[W]};
  assign sum     = wideSum[W-1:0] + wrapIn;
  assign ovf     = (addA[W-1] == addB[W-1]) && (sum[W-1] != addA[W-1]);
endmodule

// File: rtl/oca_control.sv
module oca_control
  import oca_pkg::*;
#(
  parameter int THREE_INPUT   = 1,
  parameter int FOLD_NEG_ZERO = 0,
  parameter int REG_OUT       = 1
) (
  input  logic      rstN,
  output oca_ctrl_t ctrl
);
  always_comb begin
    ctrl.useCarryIn = (THREE_INPUT != 0);
    ctrl.foldZero   = (FOLD_NEG_ZERO != 0);
    ctrl.bypass     = (REG_OUT == 0);
    ctrl.capture    = rstN && (REG_OUT != 0);
  end
endmodule

// File: rtl/oca_datapath.sv
module oca_datapath
  import oca_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  oca_ctrl_t    ctrl,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  output logic [W-1:0] rawSum,
  output logic         rawOvf,
  output logic [W-1:0] sumOut,
  output logic         overflow
);
  logic [W-1:0] stIn0 [OCA_STAGES];
  logic [W-1:0] stIn1 [OCA_STAGES];
  logic [W-1:0] stSum [OCA_STAGES];
  logic         stOvf [OCA_STAGES];
  logic [W-1:0] sumQ;
  logic         ovfQ;

  assign stIn0[0] = opA;
  assign stIn1[0] = opB;
  assign stIn0[1] = stSum[0];
  assign stIn1[1] = {{(W-1){1'b0}}, carryIn & ctrl.useCarryIn};

  for (genvar g = 0; g < OCA_STAGES; g++) begin : gStage
    eac_adder #(.W(W)) uAdd (
      .addA(stIn0[g]),
      .addB(stIn1[g]),
      .sum (stSum[g]),
      .ovf (stOvf[g])
    );
  end

  // a wrap in stage 0 undone by the +1 of stage 1 cancels out
  assign rawOvf = stOvf[0] ^ stOvf[1];
  assign rawSum = (ctrl.foldZero && (&stSum[OCA_STAGES-1])) ? '0 : stSum[OCA_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumQ <= '0;
      ovfQ <= 1'b0;
    end else if (ctrl.capture) begin
      sumQ <= rawSum;
      ovfQ <= rawOvf;
    end
  end

  assign sumOut   = ctrl.bypass ? rawSum : sumQ;
  assign overflow = ctrl.bypass ? rawOvf : ovfQ;
endmodule

// File: rtl/ones_comp_adder.sv
module ones_comp_adder
  import oca_pkg::*;
#(
  parameter int WIDTH         = 8,
  parameter int THREE_INPUT   = 1,
  parameter int FOLD_NEG_ZERO = 0,
  parameter int REG_OUT       = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             overflow
);
  oca_ctrl_t        ctrl;
  logic [WIDTH-1:0] rawSum;
  logic             rawOvf;

  oca_control #(
    .THREE_INPUT  (THREE_INPUT),
    .FOLD_NEG_ZERO(FOLD_NEG_ZERO),
    .REG_OUT      (REG_OUT)
  ) uCtrl (
    .rstN(rstN),
    .ctrl(ctrl)
  );

  oca_datapath #(.W(WIDTH)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .rawSum  (rawSum),
    .rawOvf  (rawOvf),
    .sumOut  (sumOut),
    .overflow(overflow)
  );
endmodule

// File: rtl/oca_checker.sv
module oca_checker #(
  parameter int WIDTH         = 8,
  parameter int THREE_INPUT   = 1,
  parameter int FOLD_NEG_ZERO = 0,
  parameter int REG_OUT       = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [WIDTH-1:0] rawSum,
  input logic             rawOvf,
  input logic [WIDTH-1:0] sumOut
);
  logic [1:0] liveCnt;
  logic       effCin;

  assign effCin = carryIn && (THREE_INPUT != 0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) liveCnt <= 2'd0;
    else if (liveCnt != 2'd2) liveCnt <= liveCnt + 2'd1;
  end

  // R5
  ovf_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    rawOvf |-> ((opA[WIDTH-1] == opB[WIDTH-1]) || effCin));

  // R6
  zero_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rawSum == '0) |-> ((opA == '0 && opB == '0 && !effCin) || (FOLD_NEG_ZERO != 0)));

  // R7
  fold_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (FOLD_NEG_ZERO != 0) |-> !(&rawSum));

  // R2
  add_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opB == '0 && !effCin && opA != '1) |-> (rawSum == opA));

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((REG_OUT != 0) && liveCnt == 2'd2 && $stable(opA) && $stable(opB) && $stable(carryIn))
      |=> $stable(sumOut));
endmodule

bind ones_comp_adder oca_checker #(
  .WIDTH        (WIDTH),
  .THREE_INPUT  (THREE_INPUT),
  .FOLD_NEG_ZERO(FOLD_NEG_ZERO),
  .REG_OUT      (REG_OUT)
) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .opA    (opA),
  .opB    (opB),
  .carryIn(carryIn),
  .rawSum (rawSum),
  .rawOvf (rawOvf),
  .sumOut (sumOut)
);

// File: tb/sim_ones_comp_adder.sv
module sim_ones_comp_adder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] a0 = '0, b0 = '0, s0;
  logic       c0 = 1'b0, o0;
  logic [3:0] a1 = '0, b1 = '0, s1;
  logic       c1 = 1'b0, o1;
  logic [3:0] a2 = '0, b2 = '0, s2;
  logic       c2 = 1'b0, o2;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  ones_comp_adder #(.WIDTH(8), .THREE_INPUT(1), .FOLD_NEG_ZERO(0), .REG_OUT(1)) u0 (
    .clk(clk), .rstN(rstN), .opA(a0), .opB(b0), .carryIn(c0), .sumOut(s0), .overflow(o0));
  ones_comp_adder #(.WIDTH(4), .THREE_INPUT(1), .FOLD_NEG_ZERO(1), .REG_OUT(0)) u1 (
    .clk(clk), .rstN(rstN), .opA(a1), .opB(b1), .carryIn(c1), .sumOut(s1), .overflow(o1));
  ones_comp_adder #(.WIDTH(4), .THREE_INPUT(0), .FOLD_NEG_ZERO(0), .REG_OUT(0)) u2 (
    .clk(clk), .rstN(rstN), .opA(a2), .opB(b2), .carryIn(c2), .sumOut(s2), .overflow(o2));

  // returns {overflow, sum bits}, built from signed integer values
  function automatic logic [8:0] refAdd(int w, int a, int b, int cin, bit fold);
    int modv = (1 << w) - 1;
    int mx = (1 << (w - 1)) - 1;
    int va = ((a >> (w - 1)) & 1) ? -((~a) & modv) : a;
    int vb = ((b >> (w - 1)) & 1) ? -((~b) & modv) : b;
    int tot = va + vb + cin;
    bit ov = (tot > mx) || (tot < -mx);
    int v = tot;
    int bits;
    if (v > mx) v = v - modv;
    if (v < -mx) v = v + modv;
    if (v > 0) bits = v;
    else if (v < 0) bits = (~(-v)) & modv;
    else bits = (fold || (a == 0 && b == 0 && cin == 0)) ? 0 : modv;
    return {ov, bits[7:0]};
  endfunction

  task automatic chk(string req, logic [7:0] gotS, logic gotO, logic [8:0] exp);
    checks++;
    if (gotS !== exp[7:0] || gotO !== exp[8]) begin
      failures++;
      $display("FAIL %s: got sum=%h ovf=%b expected sum=%h ovf=%b", req, gotS, gotO, exp[7:0], exp[8]);
    end
  endtask

  task automatic vec0(string req, int a, int b, int c);
    @(negedge clk);
    a0 = a[7:0]; b0 = b[7:0]; c0 = c[0];
    @(posedge clk); #1;
    chk(req, s0, o0, refAdd(8, a, b, c, 0));
  endtask

  task automatic testReset();
    a0 = 8'h35; b0 = 8'h21; c0 = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", s0, o0, 9'h000);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic testBasic();
    vec0("R2 pos+pos", 5, 3, 0);
    vec0("R2 neg+pos", 8'hFA, 3, 0);
    vec0("R2 pos+neg", 3, 8'hFA, 0);
    vec0("R2 max+min", 8'h7F, 8'h80, 0);
  endtask

  task automatic testEndAround();
    vec0("R3 -1+-1", 8'hFE, 8'hFE, 0);
    vec0("R3 -64+-63", 8'hBF, 8'hC0, 0);
    vec0("R3 20+-5", 20, 8'hFA, 0);
  endtask

  task automatic testCarryIn();
    vec0("R4 negzero+1", 8'hFF, 8'hFF, 1);
    vec0("R4 5+3+1", 5, 3, 1);
    vec0("R4 -2+0+1", 8'hFD, 0, 1);
  endtask

  task automatic testOverflow();
    vec0("R5 pos overflow", 8'h7F, 1, 0);
    vec0("R5 neg overflow", 8'h80, 8'hFE, 0);
    vec0("R5 max+negzero+1", 8'h7F, 8'hFF, 1);
    vec0("R5 cancelled wrap", 8'hFE, 8'h80, 1);
  endtask

  task automatic testZero();
    vec0("R6 x+~x", 8'h5A, 8'hA5, 0);
    vec0("R6 0+0", 0, 0, 0);
    vec0("R6 0+negzero", 0, 8'hFF, 0);
  endtask

  task automatic testLatency();
    vec0("R9 first", 9, 4, 0);
    @(negedge clk);
    a0 = 8'd1; b0 = 8'd1; c0 = 1'b0;
    #1;
    chk("R9 held before edge", s0, o0, refAdd(8, 9, 4, 0, 0));
    @(posedge clk); #1;
    chk("R9 after edge", s0, o0, refAdd(8, 1, 1, 0, 0));
  endtask

  task automatic testFoldExhaustive();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++) begin
          @(negedge clk);
          a1 = a[3:0]; b1 = b[3:0]; c1 = c[0];
          #1;
          chk("R7 fold, R9 comb", {4'h0, s1}, o1, refAdd(4, a, b, c, 1));
        end
  endtask

  task automatic testTwoInputExhaustive();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        @(negedge clk);
        a2 = a[3:0]; b2 = b[3:0]; c2 = 1'b1;
        #1;
        chk("R8 carryIn ignored", {4'h0, s2}, o2, refAdd(4, a, b, 0, 0));
      end
  endtask

  task automatic testRandom();
    for (int i = 0; i < 3000; i++)
      vec0("R2 R5 random", int'($urandom_range(255)), int'($urandom_range(255)), int'($urandom_range(1)));
  endtask

  initial begin
    testReset();
    testBasic();
    testEndAround();
    testCarryIn();
    testOverflow();
    testZero();
    testLatency();
    testFoldExhaustive();
    testTwoInputExhaustive();
    testRandom();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: got running expected done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule